// File: doc/BRIEF.md
# Two-Bank Prioritized Interrupt Controller

This block collects 64 interrupt sources into two banks of 32 and drives one interrupt request line towards a processor. Each bank keeps a pending register, a register that software writes to raise interrupts itself, and an enable mask. A hardware event input sets its pending bit for as long as it is high. A pending bit stays set until software writes a 1 to it.

The whole second bank folds into bit 0 of the first bank. That bit is not a peripheral. It is high while any second-bank source is both pending and enabled. First-bank sources are not ranked by bit position. A software-loaded table of 32 slots names one first-bank source per slot, and slot 0 ranks highest. The controller reports the number of the winning source. When the winner is the cascade bit, it reports the lowest-numbered active second-bank source, so the handler can go straight to the device.

Software reaches all registers through an APB-style slave port. Every access completes in a single access phase.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: The pending registers read at 0x00 (first bank) and 0x20 (second bank). Writing a 1 to a bit at the same address clears that bit. Writing a 0 leaves the bit unchanged.
- R2: Writing a 1 to a bit at 0x04 (first bank) or 0x24 (second bank) makes that source pending. These two addresses read as zero.
- R3: The enable masks are at 0x08 (first bank) and 0x28 (second bank). A 1 enables a source and a 0 blocks it. Both masks are zero after reset.
- R4: Source n with n below 32 is first-bank bit n. Source n of 32 or more is second-bank bit n-32.
- R5: First-bank bit 0 reads as the OR of (second-bank pending AND second-bank mask). Software set or clear writes to that bit have no effect, and neither does hardware event input 0.
- R6: Offset 0x38 reads the second-bank pending bits ANDed with the second-bank mask.
- R7: The priority table fills the eight words 0x40 to 0x5C. Slot p sits in word p/4, in byte p%4 (byte k covers bits 8k+7..8k). Bits [4:0] of that byte name the source. The top 3 bits of each byte are ignored on write and read as zero. After reset, slot p names source p.
- R8: The winner is the lowest-numbered slot whose named first-bank source is pending and enabled. A source that no slot names is never chosen.
- R9: irq is high exactly when a winner exists. The irq_src output and offset 0x60 give the winner's source number, and read 0x3F when there is no winner.
- R10: When the winner is first-bank bit 0, the reported number is 32 plus the lowest active second-bank bit.
- R11: A hardware event input sets its pending bit on every clock edge at which it is high. If a hardware set and a software clear hit the same bit in the same cycle, the bit stays set.
- R12: A write takes effect at the clock edge that ends its access phase, and irq and irq_src follow in that same cycle. Unmapped or misaligned offsets read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| hw_evt | input | 64 | Level-sensitive hardware events, bit n is source n |
| irq | output | 1 | Interrupt request |
| irq_src | output | 6 | Number of the winning source, 0x3F when none |

## Verification
The bench loads a priority table that puts a higher-numbered source ahead of a lower one. A controller that ranks sources by bit position would report the wrong number there. The same table also leaves two sources named by no slot, and a controller that scanned raw bits would raise irq for them. For the cascade, the bench checks that a pending but disabled second-bank bit stays out of bank 0 bit 0, and that the lowest second-bank bit is the one reported. It also holds a hardware event high across a software clear of the same bit, so a controller that lets the clear win would lose that interrupt.

// File: rtl/dbic_pkg.sv
`timescale 1ns/1ps
package dbic_pkg;
  localparam int unsigned BANK_W   = 32;
  localparam int unsigned NUM_BANK = 2;
  localparam int unsigned SRC_TOT  = BANK_W * NUM_BANK;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned SLOTS    = 32;
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned TBL_REGS = SLOTS / LANES;
  localparam int unsigned IDX_W    = $clog2(BANK_W);
  localparam int unsigned SRC_W    = $clog2(SRC_TOT);
  localparam int unsigned TBL_IW   = $clog2(TBL_REGS);
  localparam int unsigned LANE_IW  = $clog2(LANES);

  localparam logic [SRC_W-1:0] SRC_NONE = '1;

  localparam logic [ADDR_W-1:0] OFS_PEND0 = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_RAISE0 = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_EN0 = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_PEND1 = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAISE1 = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_EN1 = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LIVE1 = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_TBL = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_WIN = 8'h60;
endpackage

// File: rtl/dbic_bank.sv
`timescale 1ns/1ps
module dbic_bank #(
  parameter int unsigned W       = 32,
  parameter bit          CASCADE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] hw_evt,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wd,
  input  logic         cascade_in,
  output logic [W-1:0] status_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] active_o
);
  localparam logic [W-1:0] LIVE = CASCADE ? {{(W-1){1'b1}}, 1'b0} : {W{1'b1}};

  logic [W-1:0] st_q, st_d;
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    st_d   = ((st_q & ~sw_clr) | sw_set | hw_evt) & LIVE;
    mask_d = mask_we ? mask_wd : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      mask_q <= '0;
    end else begin
      st_q <= st_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  generate
    if (CASCADE) begin : g_casc
      assign status_o = {st_q[W-1:1], st_q[0] | cascade_in};
    end else begin : g_flat
      logic unused_casc;
      assign unused_casc = cascade_in;
      assign status_o    = st_q;
    end
  endgenerate

  assign mask_o   = mask_q;
  assign active_o = status_o & mask_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hw_evt & LIVE)) |=> ((st_q & $past(hw_evt & LIVE)) == $past(hw_evt & LIVE))); // R11

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sw_clr & ~sw_set & ~hw_evt)) |=> ((st_q & $past(sw_clr & ~sw_set & ~hw_evt)) == '0)); // R1

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R3
endmodule

// File: rtl/dbic_prio_table.sv
`timescale 1ns/1ps
module dbic_prio_table
  import dbic_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [TBL_IW-1:0]            wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [TBL_IW-1:0]            rd_idx,
  output logic [DATA_W-1:0]            rd_data,
  output logic [SLOTS-1:0][IDX_W-1:0]  slot_src
);
  logic [SLOTS-1:0][IDX_W-1:0] slot_q, slot_d;

  genvar p;
  generate
    for (p = 0; p < SLOTS; p++) begin : g_slot
      localparam logic [IDX_W-1:0]  RST_SRC = IDX_W'(p);
      localparam logic [TBL_IW-1:0] MY_REG  = TBL_IW'(p / LANES);
      localparam int unsigned       LSB     = 8 * (p % LANES);
      always_comb begin
        slot_d[p] = slot_q[p];
        if (wr_en && (wr_idx == MY_REG)) slot_d[p] = wr_data[LSB +: IDX_W];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q[p] <= RST_SRC;
        else        slot_q[p] <= slot_d[p];
      end
    end
  endgenerate

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      localparam logic [LANE_IW-1:0] LN = LANE_IW'(l);
      assign rd_data[8*l +: 8] = {{(8-IDX_W){1'b0}}, slot_q[{rd_idx, LN}]};
    end
  endgenerate

  assign slot_src = slot_q;
endmodule

// File: rtl/dbic_prio_sel.sv
`timescale 1ns/1ps
module dbic_prio_sel
  import dbic_pkg::*;
(
  input  logic [SLOTS-1:0][IDX_W-1:0] slot_src,
  input  logic [BANK_W-1:0]           active0,
  input  logic [BANK_W-1:0]           active1,
  output logic                        found,
  output logic [SRC_W-1:0]            src_num
);
  logic [SLOTS-1:0]            hit;
  logic [SLOTS:0]              seen;
  logic [SLOTS:0][IDX_W-1:0]   win_acc;
  logic [BANK_W:0]             seen1;
  logic [BANK_W:0][IDX_W-1:0]  low_acc;

  assign seen[0]    = 1'b0;
  assign win_acc[0] = '0;
  assign seen1[0]   = 1'b0;
  assign low_acc[0] = '0;

  genvar p;
  generate
    for (p = 0; p < SLOTS; p++) begin : g_slot
      assign hit[p]       = active0[slot_src[p]];
      assign seen[p+1]    = seen[p] | hit[p];
      assign win_acc[p+1] = win_acc[p] | ({IDX_W{hit[p] & ~seen[p]}} & slot_src[p]);
    end
  endgenerate

  genvar i;
  generate
    for (i = 0; i < BANK_W; i++) begin : g_low
      localparam logic [IDX_W-1:0] BIT_NUM = IDX_W'(i);
      assign seen1[i+1]   = seen1[i] | active1[i];
      assign low_acc[i+1] = low_acc[i] | ({IDX_W{active1[i] & ~seen1[i]}} & BIT_NUM);
    end
  endgenerate

  always_comb begin
    found = seen[SLOTS];
    if (!found)                    src_num = SRC_NONE;
    else if (win_acc[SLOTS] == '0) src_num = {1'b1, low_acc[BANK_W]};
    else                           src_num = {1'b0, win_acc[SLOTS]};
  end
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl
  import dbic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  input  logic [SRC_TOT-1:0]   hw_evt,
  output logic                 irq,
  output logic [SRC_W-1:0]     irq_src
);
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic                acc_wr;
  logic [ADDR_W-1:0]   tbl_off;
  logic                tbl_hit;
  logic [TBL_IW-1:0]   tbl_idx;
  logic [BANK_W-1:0]   set0, clr0, set1, clr1;
  logic                en0_we, en1_we;

  assign acc_wr  = psel & penable & pwrite;
  assign tbl_off = paddr - OFS_TBL;
  assign tbl_hit = (paddr[1:0] == 2'b00) && (paddr >= OFS_TBL) &&
                   (tbl_off < ADDR_W'(4 * TBL_REGS));
  assign tbl_idx = tbl_off[2 +: TBL_IW];

  always_comb begin
    set0   = (acc_wr && paddr == OFS_RAISE0) ? pwdata : '0;
    clr0   = (acc_wr && paddr == OFS_PEND0)  ? pwdata : '0;
    set1   = (acc_wr && paddr == OFS_RAISE1) ? pwdata : '0;
    clr1   = (acc_wr && paddr == OFS_PEND1)  ? pwdata : '0;
    en0_we = acc_wr && (paddr == OFS_EN0);
    en1_we = acc_wr && (paddr == OFS_EN1);
  end

  logic [BANK_W-1:0] status0, mask0, active0;
  logic [BANK_W-1:0] status1, mask1, active1;

  dbic_bank #(.W(BANK_W), .CASCADE(1'b0)) u_bank1 (
    .clk(clk), .rst_n(rst_sync),
    .sw_set(set1), .sw_clr(clr1), .hw_evt(hw_evt[SRC_TOT-1:BANK_W]),
    .mask_we(en1_we), .mask_wd(pwdata), .cascade_in(1'b0),
    .status_o(status1), .mask_o(mask1), .active_o(active1)
  );

  dbic_bank #(.W(BANK_W), .CASCADE(1'b1)) u_bank0 (
    .clk(clk), .rst_n(rst_sync),
    .sw_set(set0), .sw_clr(clr0), .hw_evt(hw_evt[BANK_W-1:0]),
    .mask_we(en0_we), .mask_wd(pwdata), .cascade_in(|active1),
    .status_o(status0), .mask_o(mask0), .active_o(active0)
  );

  logic [DATA_W-1:0]           tbl_rd;
  logic [SLOTS-1:0][IDX_W-1:0] slot_src;

  dbic_prio_table u_table (
    .clk(clk), .rst_n(rst_sync),
    .wr_en(acc_wr & tbl_hit), .wr_idx(tbl_idx), .wr_data(pwdata),
    .rd_idx(tbl_idx), .rd_data(tbl_rd), .slot_src(slot_src)
  );

  dbic_prio_sel u_sel (
    .slot_src(slot_src), .active0(active0), .active1(active1),
    .found(irq), .src_num(irq_src)
  );

  always_comb begin
    prdata = '0;
    if (tbl_hit) prdata = tbl_rd;
    else begin
      case (paddr)
        OFS_PEND0: prdata = status0;
        OFS_EN0:   prdata = mask0;
        OFS_PEND1: prdata = status1;
        OFS_EN1:   prdata = mask1;
        OFS_LIVE1: prdata = active1;
        OFS_WIN:   prdata = DATA_W'(irq_src);
        default:   prdata = '0;
      endcase
    end
  end

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_sync)
    !irq |-> (irq_src == SRC_NONE)); // R9

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_sync)
    (mask0 == '0) |-> !irq); // R3

  AST_CASCADE_PICK: assert property (@(posedge clk) disable iff (!rst_sync)
    (irq && irq_src[IDX_W]) |-> active1[irq_src[IDX_W-1:0]]); // R10

  AST_PICK_LIVE: assert property (@(posedge clk) disable iff (!rst_sync)
    (irq && !irq_src[IDX_W]) |-> active0[irq_src[IDX_W-1:0]]); // R8

  AST_CASCADE_BIT: assert property (@(posedge clk) disable iff (!rst_sync)
    (mask1 == '0) |-> !status0[0]); // R5
endmodule

// File: tb/dual_bank_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [63:0] hw_evt = '0;
  logic        irq;
  logic [5:0]  irq_src;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dual_bank_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .hw_evt(hw_evt),
    .irq(irq), .irq_src(irq_src)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic chk_out(input string tag, input logic exp_irq, input logic [5:0] exp_src);
    check({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq});
    check({tag, " irq_src"}, {26'd0, irq_src}, {26'd0, exp_src});
  endtask

  task automatic t_reset;
    chk_out("R9 reset", 1'b0, 6'h3F);
    chk_rd("R3 reset mask0", 8'h08, 32'h0);
    chk_rd("R3 reset mask1", 8'h28, 32'h0);
    chk_rd("R7 reset table word0", 8'h40, 32'h03020100);
    chk_rd("R9 reset code at 0x60", 8'h60, 32'h3F);
  endtask

  task automatic t_soft_raise;
    wr(8'h04, 32'h20);
    chk_rd("R2 raise sets pending", 8'h00, 32'h20);
    chk_rd("R2 raise reads zero", 8'h04, 32'h0);
    chk_out("R3 masked source blocked", 1'b0, 6'h3F);
    wr(8'h08, 32'h20);
    chk_out("R12 enable takes effect, R4 source 5", 1'b1, 6'd5);
    wr(8'h00, 32'h0);
    chk_rd("R1 zero write keeps bit", 8'h00, 32'h20);
    wr(8'h00, 32'h20);
    chk_rd("R1 w1c clears", 8'h00, 32'h0);
    chk_out("R1 cleared drops irq", 1'b0, 6'h3F);
    wr(8'h08, 32'h0);
  endtask

  task automatic t_priority;
    wr(8'h40, 32'h000005E9);
    chk_rd("R7 lane low bits only", 8'h40, 32'h00000509);
    wr(8'h04, 32'h220);
    wr(8'h08, 32'h22C);
    chk_out("R8 table order beats bit order", 1'b1, 6'd9);
    wr(8'h00, 32'h200);
    chk_out("R8 next slot wins", 1'b1, 6'd5);
    wr(8'h00, 32'h20);
    wr(8'h04, 32'hC);
    chk_rd("R8 unnamed sources pending", 8'h00, 32'hC);
    chk_out("R8 unnamed sources never chosen", 1'b0, 6'h3F);
    wr(8'h00, 32'hFFFFFFFF);
    wr(8'h08, 32'h0);
    wr(8'h40, 32'h03020100);
  endtask

  task automatic t_cascade;
    wr(8'h24, 32'h10);
    chk_rd("R5 disabled bank1 bit not folded", 8'h00, 32'h0);
    wr(8'h28, 32'h10);
    chk_rd("R6 live bank1 view", 8'h38, 32'h10);
    chk_rd("R5 cascade bit reads set", 8'h00, 32'h1);
    chk_out("R3 cascade needs mask0 bit0", 1'b0, 6'h3F);
    wr(8'h08, 32'h1);
    chk_out("R10 cascade reports 36", 1'b1, 6'd36);
    wr(8'h24, 32'h4);
    wr(8'h28, 32'h14);
    chk_out("R10 lowest bank1 bit reported", 1'b1, 6'd34);
    chk_rd("R9 0x60 matches", 8'h60, 32'd34);
    wr(8'h00, 32'h1);
    chk_rd("R5 clear of cascade bit ignored", 8'h00, 32'h1);
    wr(8'h04, 32'h80);
    wr(8'h08, 32'h81);
    chk_out("R8 slot 0 cascade outranks source 7", 1'b1, 6'd34);
    wr(8'h20, 32'h14);
    chk_rd("R6 live view after clear", 8'h38, 32'h0);
    chk_out("R8 source 7 after cascade drains", 1'b1, 6'd7);
    wr(8'h00, 32'h80);
    wr(8'h04, 32'h1);
    chk_rd("R5 raise of bit0 ignored", 8'h00, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_hw_events;
    @(negedge clk); hw_evt[12] = 1'b1;
    @(negedge clk); hw_evt[12] = 1'b0;
    chk_rd("R11 one-cycle pulse latched", 8'h00, 32'h1000);
    @(negedge clk); hw_evt[40] = 1'b1;
    @(negedge clk); hw_evt[40] = 1'b0;
    chk_rd("R4 source 40 is bank1 bit 8", 8'h20, 32'h100);
    @(negedge clk); hw_evt[12] = 1'b1;
    wr(8'h00, 32'h1000);
    @(negedge clk); hw_evt[12] = 1'b0;
    chk_rd("R11 set wins over clear", 8'h00, 32'h1000);
    wr(8'h00, 32'h1000);
    chk_rd("R1 clear after event drops", 8'h00, 32'h0);
    @(negedge clk); hw_evt[0] = 1'b1;
    @(negedge clk); hw_evt[0] = 1'b0;
    chk_rd("R5 event 0 ignored", 8'h00, 32'h0);
    wr(8'h20, 32'h100);
  endtask

  task automatic t_unmapped;
    wr(8'h10, 32'hFFFFFFFF);
    chk_rd("R12 unmapped reads zero", 8'h10, 32'h0);
    wr(8'h0C, 32'hFFFFFFFF);
    wr(8'h09, 32'hFFFFFFFF);
    chk_rd("R12 stray writes leave mask0", 8'h08, 32'h0);
    chk_rd("R12 stray writes leave mask1", 8'h28, 32'h0);
    chk_rd("R12 misaligned reads zero", 8'h41, 32'h0);
    chk_rd("R7 table word1 intact", 8'h44, 32'h07060504);
    chk_out("R12 idle after stray writes", 1'b0, 6'h3F);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_soft_raise();
    t_priority();
    t_cascade();
    t_hw_events();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule